// File: doc/BRIEF.md
# ADD Instruction Byte Decoder

This block turns the byte stream of a single integer ADD instruction into a decoded operation record. Bytes arrive one per cycle over a valid/ready handshake. A mode input selects between the 64-bit execution mode and the legacy mode. The decoder accepts any number of operand-size (0x66) and LOCK (0xF0) prefixes. In 64-bit mode it also accepts a REX byte. It then takes one opcode byte, an optional ModRM byte and an immediate of zero, one, two or four bytes.

Once the last byte of the instruction has been taken, the block presents a record for one cycle. The record holds the operand width, the destination and source register numbers, the high-byte and memory flags, whether the source is an immediate, the sign-extended immediate and a fault flag. Effective-address bytes (SIB, displacement) and the memory access itself belong to later stages. For a memory operand the decoder only reports that the ModRM byte selects memory, together with the 3-bit r/m field, extended by the REX base bit.

Top module: `addop_decode`

## Requirements
- R1: `in_ready` is high in every cycle except the record cycle, where it is low. A byte is consumed on a rising edge only when `in_valid` and `in_ready` are both high. Values on `in_byte` while `in_valid` is low, or during the record cycle, have no effect.
- R2: `out_valid` is high for exactly one cycle. That cycle follows directly after the edge that consumed the instruction's last byte.
- R3: `out_size` uses 0 for 8 bits, 1 for 16, 2 for 32 and 3 for 64. The size is 8 bits when opcode bit 0 is 0. Otherwise it is 64 bits if a REX byte with W (bit 3) set is in effect. If not, it is 16 bits when a 0x66 prefix was seen, and 32 bits in all other cases.
- R4: Opcode 0x04 takes a 1-byte immediate. Opcode 0x05 takes a 2-byte immediate at 16 bits and a 4-byte immediate otherwise. Both forms have no ModRM byte and give destination 0, source flagged as immediate, source index 0 and no memory flags.
- R5: Opcodes 0x80 and 0x83 take a 1-byte immediate, and 0x81 takes the 2- or 4-byte immediate. In all three, ModRM bits 5:3 must be 0, and the r/m operand is the destination. Any other value in bits 5:3 produces a fault record right after the ModRM byte, and no immediate is consumed.
- R6: In opcodes 0x00 to 0x03, bit 1 picks the direction. With bit 1 at 0, the r/m operand is the destination and the reg field (ModRM bits 5:3) is the source. With bit 1 at 1, the roles are swapped.
- R7: In 64-bit mode, a byte 0x40 to 0x4F is a REX byte. Its bit 2 becomes bit 3 of the reg-field index, and its bit 0 becomes bit 3 of the r/m index. A REX byte counts only when no prefix follows it before the opcode.
- R8: In legacy mode, bytes 0x40 to 0x4F are treated as opcodes. Each one produces a fault record right after it is consumed, and the size can never be 64 bits.
- R9: `out_dst_hi` and `out_src_hi` are set for a register operand with index 4 to 7 at 8-bit size when no REX byte is in effect. A REX byte makes those indices plain low-byte registers.
- R10: Immediate bytes arrive least significant first. The value is sign-extended from its own length to the operand size, and the bits above the operand size are 0. When there is no immediate, `out_imm` is 0.
- R11: A LOCK prefix faults when the destination is a register. That covers ModRM bits 7:6 equal to 3, the 0x02/0x03 forms and the 0x04/0x05 forms. The whole instruction is still consumed. LOCK with a memory destination decodes normally.
- R12: Any opcode outside 0x00–0x05, 0x80, 0x81 and 0x83 produces a fault record right after the opcode byte is consumed.
- R13: ModRM bits 7:6 other than 3 mark the r/m operand as memory. This sets `out_dst_mem` or `out_src_mem`, depending on which role the r/m operand plays. The two flags are never set together. When `out_invalid` is set, the other record fields carry no meaning.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode64 | input | 1 | 1 selects 64-bit mode, 0 selects legacy mode; held stable within an instruction |
| in_valid | input | 1 | A byte is offered on `in_byte` |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Decoder can take a byte this cycle |
| out_valid | output | 1 | Record present (one-cycle pulse) |
| out_size | output | 2 | Operand size code (0:8, 1:16, 2:32, 3:64) |
| out_dst | output | 4 | Destination register index |
| out_dst_hi | output | 1 | Destination is a high byte register |
| out_dst_mem | output | 1 | Destination is a memory operand |
| out_src | output | 4 | Source register index (0 for immediate source) |
| out_src_hi | output | 1 | Source is a high byte register |
| out_src_mem | output | 1 | Source is a memory operand |
| out_src_imm | output | 1 | Source is the immediate |
| out_imm | output | XLEN | Sign-extended, size-masked immediate |
| out_invalid | output | 1 | Invalid-opcode fault |

## Verification
Two events can land in the same cycle: the record is presented, and the first byte of the next instruction, or a stale byte, is offered. The driver keeps `in_valid` high with a byte on `in_byte` throughout the record cycle and starts the next instruction straight away. If that byte were swallowed, the next scoreboard record would show the wrong size, registers or a spurious fault. A second overlap comes from a LOCK prefix combined with a register destination. There the fault is decided at the opcode or ModRM byte, but the record must still wait for the final immediate byte. The scoreboard confirms this by checking that the next instruction decodes cleanly.

// File: rtl/addop_pkg.sv
package addop_pkg;

   // operand size code as presented on out_size
   typedef enum logic [1:0] {
      SZ8  = 2'd0,
      SZ16 = 2'd1,
      SZ32 = 2'd2,
      SZ64 = 2'd3
   } opsz_e;

   // kind of immediate that follows the opcode / ModRM
   typedef enum logic [1:0] {
      IK_NONE = 2'd0,
      IK_BYTE = 2'd1,
      IK_FULL = 2'd2
   } immk_e;

   // operand arrangement of an opcode
   typedef enum logic [1:0] {
      FM_ACC = 2'd0,
      FM_GRP = 2'd1,
      FM_MR  = 2'd2,
      FM_RM  = 2'd3
   } form_e;

   typedef enum logic [1:0] {
      ST_PFX   = 2'd0,
      ST_MODRM = 2'd1,
      ST_IMM   = 2'd2,
      ST_EMIT  = 2'd3
   } dstate_e;

   typedef struct packed {
      logic  known;
      logic  has_modrm;
      form_e form;
      logic  wide;
      immk_e immk;
   } opcls_t;

   localparam logic [7:0] PFX_OSZ  = 8'h66;
   localparam logic [7:0] PFX_LOCK = 8'hF0;
   localparam logic [3:0] REX_HI   = 4'h4;

   function automatic opsz_e pick_size(input logic wide, input logic rexw,
                                       input logic osz);
      opsz_e s;
      if (!wide)     s = SZ8;
      else if (rexw) s = SZ64;
      else if (osz)  s = SZ16;
      else           s = SZ32;
      return s;
   endfunction

   function automatic int unsigned imm_bytes(input immk_e k, input opsz_e s);
      int unsigned n;
      case (k)
         IK_BYTE: n = 1;
         IK_FULL: n = (s == SZ16) ? 2 : 4;
         default: n = 0;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/addop_opclass.sv
module addop_opclass
   import addop_pkg::*;
(
   input  logic [7:0] opc,
   output opcls_t     cls
);

   always_comb begin
      cls = '{known: 1'b0, has_modrm: 1'b0, form: FM_ACC, wide: 1'b0, immk: IK_NONE};
      case (opc)
         8'h00: cls = '{known: 1'b1, has_modrm: 1'b1, form: FM_MR,  wide: 1'b0, immk: IK_NONE};
         8'h01: cls = '{known: 1'b1, has_modrm: 1'b1, form: FM_MR,  wide: 1'b1, immk: IK_NONE};
         8'h02: cls = '{known: 1'b1, has_modrm: 1'b1, form: FM_RM,  wide: 1'b0, immk: IK_NONE};
         8'h03: cls = '{known: 1'b1, has_modrm: 1'b1, form: FM_RM,  wide: 1'b1, immk: IK_NONE};
         8'h04: cls = '{known: 1'b1, has_modrm: 1'b0, form: FM_ACC, wide: 1'b0, immk: IK_BYTE};
         8'h05: cls = '{known: 1'b1, has_modrm: 1'b0, form: FM_ACC, wide: 1'b1, immk: IK_FULL};
         8'h80: cls = '{known: 1'b1, has_modrm: 1'b1, form: FM_GRP, wide: 1'b0, immk: IK_BYTE};
         8'h81: cls = '{known: 1'b1, has_modrm: 1'b1, form: FM_GRP, wide: 1'b1, immk: IK_FULL};
         8'h83: cls = '{known: 1'b1, has_modrm: 1'b1, form: FM_GRP, wide: 1'b1, immk: IK_BYTE};
         default: ;
      endcase
   end

endmodule

// File: rtl/addop_immasm.sv
module addop_immasm
   import addop_pkg::*;
#(
   parameter  int XLEN      = 64,
   parameter  int IMM_BYTES = 4,
   localparam int IDXW      = $clog2(IMM_BYTES + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            take,
   input  logic [IDXW-1:0] idx,
   input  logic [7:0]      din,
   input  logic [IDXW-1:0] len,
   input  opsz_e           size,
   output logic [XLEN-1:0] value
);

   localparam int OUT_B = XLEN / 8;

   logic [7:0] lane [IMM_BYTES];
   logic       sgn;
   int         size_b;

   // one capture register per immediate byte, little-endian order
   for (genvar g = 0; g < IMM_BYTES; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                             lane[g] <= '0;
         else if (take && idx == IDXW'(g))       lane[g] <= din;
      end
   end

   always_comb begin
      sgn = 1'b0;
      for (int i = 0; i < IMM_BYTES; i++)
         if (len == IDXW'(i + 1)) sgn = lane[i][7];
   end

   assign size_b = 1 << size;

   for (genvar b = 0; b < OUT_B; b++) begin : g_out
      logic [7:0] raw;
      if (b < IMM_BYTES) begin : g_cap
         assign raw = (IDXW'(b) < len) ? lane[b] : {8{sgn}};
      end else begin : g_ext
         assign raw = {8{sgn}};
      end
      assign value[8*b +: 8] = (b < size_b) ? raw : 8'h00;
   end

endmodule

// File: rtl/addop_regmap.sv
module addop_regmap
   import addop_pkg::*;
(
   input  form_e      form,
   input  opsz_e      size,
   input  logic       rex_on,
   input  logic       rex_r,
   input  logic       rex_b,
   input  logic [7:0] modrm,
   output logic [3:0] dst,
   output logic       dst_hi,
   output logic       dst_mem,
   output logic [3:0] src,
   output logic       src_hi,
   output logic       src_mem,
   output logic       src_imm
);

   logic [3:0] reg_i;
   logic [3:0] rm_i;
   logic       on_mem;

   assign reg_i  = {rex_on & rex_r, modrm[5:3]};
   assign rm_i   = {rex_on & rex_b, modrm[2:0]};
   assign on_mem = (modrm[7:6] != 2'b11);

   always_comb begin
      dst     = '0;
      src     = '0;
      dst_mem = 1'b0;
      src_mem = 1'b0;
      src_imm = 1'b0;
      case (form)
         FM_ACC: src_imm = 1'b1;
         FM_GRP: begin
            dst     = rm_i;
            dst_mem = on_mem;
            src_imm = 1'b1;
         end
         FM_MR: begin
            dst     = rm_i;
            dst_mem = on_mem;
            src     = reg_i;
         end
         default: begin
            dst     = reg_i;
            src     = rm_i;
            src_mem = on_mem;
         end
      endcase
      dst_hi = (size == SZ8) && !rex_on && !dst_mem && dst[2];
      src_hi = (size == SZ8) && !rex_on && !src_mem && !src_imm && src[2];
   end

endmodule

// File: rtl/addop_decode.sv
module addop_decode
   import addop_pkg::*;
#(
   parameter int XLEN      = 64,
   parameter int IMM_BYTES = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            mode64,
   input  logic            in_valid,
   input  logic [7:0]      in_byte,
   output logic            in_ready,
   output logic            out_valid,
   output logic [1:0]      out_size,
   output logic [3:0]      out_dst,
   output logic            out_dst_hi,
   output logic            out_dst_mem,
   output logic [3:0]      out_src,
   output logic            out_src_hi,
   output logic            out_src_mem,
   output logic            out_src_imm,
   output logic [XLEN-1:0] out_imm,
   output logic            out_invalid
);

   localparam int IDXW = $clog2(IMM_BYTES + 1);

   if (XLEN < 64 || (XLEN % 8) != 0) begin : g_bad_xlen
      $error("addop_decode: XLEN must be a multiple of 8 and at least 64");
   end
   if (IMM_BYTES < 4) begin : g_bad_imm
      $error("addop_decode: IMM_BYTES must be at least 4");
   end

   dstate_e         st_q;
   logic            lock_q, osz_q, inv_q;
   logic            rexv_q, rexw_q, rexr_q, rexb_q;
   form_e           form_q;
   opsz_e           size_q;
   opsz_e           size_now;
   logic [IDXW-1:0] len_q, idx_q;
   logic [7:0]      modrm_q;
   opcls_t          cls_now;
   logic            take;
   logic            is_rex;

   assign in_ready = (st_q != ST_EMIT);
   assign take     = in_valid && in_ready;
   assign is_rex   = mode64 && (in_byte[7:4] == REX_HI);

   addop_opclass u_cls (
      .opc (in_byte),
      .cls (cls_now)
   );

   assign size_now = pick_size(cls_now.wide, rexv_q & rexw_q, osz_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_PFX;
         lock_q  <= 1'b0;
         osz_q   <= 1'b0;
         inv_q   <= 1'b0;
         rexv_q  <= 1'b0;
         rexw_q  <= 1'b0;
         rexr_q  <= 1'b0;
         rexb_q  <= 1'b0;
         form_q  <= FM_ACC;
         size_q  <= SZ8;
         len_q   <= '0;
         idx_q   <= '0;
         modrm_q <= '0;
      end else begin
         case (st_q)
            ST_PFX: if (take) begin
               if (in_byte == PFX_OSZ) begin
                  osz_q  <= 1'b1;
                  rexv_q <= 1'b0;
               end else if (in_byte == PFX_LOCK) begin
                  lock_q <= 1'b1;
                  rexv_q <= 1'b0;
               end else if (is_rex) begin
                  rexv_q <= 1'b1;
                  rexw_q <= in_byte[3];
                  rexr_q <= in_byte[2];
                  rexb_q <= in_byte[0];
               end else begin
                  form_q <= cls_now.form;
                  size_q <= size_now;
                  len_q  <= IDXW'(imm_bytes(cls_now.immk, size_now));
                  idx_q  <= '0;
                  if (!cls_now.known) begin
                     inv_q <= 1'b1;
                     st_q  <= ST_EMIT;
                  end else if (cls_now.has_modrm) begin
                     st_q  <= ST_MODRM;
                  end else begin
                     inv_q <= lock_q;
                     st_q  <= ST_IMM;
                  end
               end
            end
            ST_MODRM: if (take) begin
               modrm_q <= in_byte;
               if (form_q == FM_GRP && in_byte[5:3] != 3'd0) begin
                  inv_q <= 1'b1;
                  st_q  <= ST_EMIT;
               end else begin
                  inv_q <= lock_q && (in_byte[7:6] == 2'b11 || form_q == FM_RM);
                  st_q  <= (len_q == '0) ? ST_EMIT : ST_IMM;
               end
            end
            ST_IMM: if (take) begin
               idx_q <= idx_q + IDXW'(1);
               if (idx_q + IDXW'(1) == len_q) st_q <= ST_EMIT;
            end
            default: begin
               lock_q <= 1'b0;
               osz_q  <= 1'b0;
               inv_q  <= 1'b0;
               rexv_q <= 1'b0;
               st_q   <= ST_PFX;
            end
         endcase
      end
   end

   addop_immasm #(
      .XLEN      (XLEN),
      .IMM_BYTES (IMM_BYTES)
   ) u_imm (
      .clk   (clk),
      .rst_n (rst_n),
      .take  (take && st_q == ST_IMM),
      .idx   (idx_q),
      .din   (in_byte),
      .len   (len_q),
      .size  (size_q),
      .value (out_imm)
   );

   addop_regmap u_map (
      .form    (form_q),
      .size    (size_q),
      .rex_on  (rexv_q),
      .rex_r   (rexr_q),
      .rex_b   (rexb_q),
      .modrm   (modrm_q),
      .dst     (out_dst),
      .dst_hi  (out_dst_hi),
      .dst_mem (out_dst_mem),
      .src     (out_src),
      .src_hi  (out_src_hi),
      .src_mem (out_src_mem),
      .src_imm (out_src_imm)
   );

   assign out_valid   = (st_q == ST_EMIT);
   assign out_size    = size_q;
   assign out_invalid = inv_q;

endmodule

// File: rtl/addop_decode_chk.sv
module addop_decode_chk #(
   parameter int XLEN = 64
) (
   input logic            clk,
   input logic            rst_n,
   input logic            mode64,
   input logic            in_ready,
   input logic            out_valid,
   input logic [1:0]      out_size,
   input logic            out_dst_hi,
   input logic            out_dst_mem,
   input logic            out_src_hi,
   input logic            out_src_mem,
   input logic            out_src_imm,
   input logic [XLEN-1:0] out_imm,
   input logic            out_invalid
);

   // R2
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   // R1
   ready_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready);

   // R9
   hi_byte_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_invalid && out_size != 2'd0) |-> !(out_dst_hi || out_src_hi));

   // R13
   one_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_invalid) |-> !(out_dst_mem && out_src_mem));

   // R10
   imm_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_invalid && out_size == 2'd0) |-> (out_imm[XLEN-1:8] == '0));

   // R4
   imm_src_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_invalid && out_src_imm) |-> !(out_src_mem || out_src_hi));

   // R8
   legacy_no64_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_invalid && !mode64) |-> (out_size != 2'd3));

endmodule

bind addop_decode addop_decode_chk #(.XLEN(XLEN)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mode64      (mode64),
   .in_ready    (in_ready),
   .out_valid   (out_valid),
   .out_size    (out_size),
   .out_dst_hi  (out_dst_hi),
   .out_dst_mem (out_dst_mem),
   .out_src_hi  (out_src_hi),
   .out_src_mem (out_src_mem),
   .out_src_imm (out_src_imm),
   .out_imm     (out_imm),
   .out_invalid (out_invalid)
);

// File: tb/sim_addop_decode.sv
`timescale 1ns/100ps
module sim_addop_decode;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode64 = 1'b1;
   logic        in_valid = 1'b0;
   logic [7:0]  in_byte = 8'h00;
   logic        in_ready, out_valid;
   logic [1:0]  out_size;
   logic [3:0]  out_dst, out_src;
   logic        out_dst_hi, out_dst_mem, out_src_hi, out_src_mem, out_src_imm;
   logic [63:0] out_imm;
   logic        out_invalid;

   int n_chk = 0;
   int n_err = 0;

   always #2.5 clk = ~clk;

   addop_decode u0 (
      .clk(clk), .rst_n(rst_n), .mode64(mode64),
      .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
      .out_valid(out_valid), .out_size(out_size),
      .out_dst(out_dst), .out_dst_hi(out_dst_hi), .out_dst_mem(out_dst_mem),
      .out_src(out_src), .out_src_hi(out_src_hi), .out_src_mem(out_src_mem),
      .out_src_imm(out_src_imm), .out_imm(out_imm), .out_invalid(out_invalid)
   );

   typedef struct {
      string       req;
      logic        inv;
      logic [1:0]  sz;
      logic [3:0]  d;
      logic        dh, dm;
      logic [3:0]  s;
      logic        sh, sm, si;
      logic [63:0] imm;
   } exp_t;

   exp_t sbq[$];

   function automatic exp_t mk(string r, logic [1:0] sz, logic [3:0] d, logic dh,
                               logic dm, logic [3:0] s, logic sh, logic sm,
                               logic si, logic [63:0] imm);
      exp_t e;
      e.req = r; e.inv = 1'b0; e.sz = sz; e.d = d; e.dh = dh; e.dm = dm;
      e.s = s; e.sh = sh; e.sm = sm; e.si = si; e.imm = imm;
      return e;
   endfunction

   function automatic exp_t mkinv(string r);
      exp_t e;
      e = mk(r, 2'd0, 4'd0, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 64'd0);
      e.inv = 1'b1;
      return e;
   endfunction

   task automatic push(input exp_t e);
      sbq.push_back(e);
   endtask

   // offer a byte and hold it until the edge that consumes it
   task automatic put(input logic [7:0] b);
      @(negedge clk);
      in_valid = 1'b1;
      in_byte  = b;
      while (!in_ready) @(negedge clk);
   endtask

   task automatic idle(input int n, input logic m);
      @(negedge clk);
      in_valid = 1'b0;
      in_byte  = 8'h66;   // junk with valid low must be ignored (R1)
      mode64   = m;
      repeat (n - 1) @(negedge clk);
   endtask

   // R2: record must be present right after the last consumed byte
   task automatic expect_emit(input string r);
      @(negedge clk);
      n_chk++;
      if (!out_valid) begin
         n_err++;
         $display("FAIL %s: out_valid=%0b expected 1 after last byte", r, out_valid);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         exp_t e;
         n_chk++;
         if (in_ready) begin   // R1
            n_err++;
            $display("FAIL R1: in_ready=%0b expected 0 in record cycle", in_ready);
         end
         n_chk++;
         if (sbq.size() == 0) begin
            n_err++;
            $display("FAIL R2: unexpected record got inv=%0b expected none", out_invalid);
         end else begin
            e = sbq.pop_front();
            if (e.inv) begin
               if (!out_invalid) begin
                  n_err++;
                  $display("FAIL %s: out_invalid=%0b expected 1", e.req, out_invalid);
               end
            end else if (out_invalid !== 1'b0 || out_size !== e.sz || out_dst !== e.d ||
                         out_dst_hi !== e.dh || out_dst_mem !== e.dm || out_src !== e.s ||
                         out_src_hi !== e.sh || out_src_mem !== e.sm ||
                         out_src_imm !== e.si || out_imm !== e.imm) begin
               n_err++;
               $display("FAIL %s: got inv=%0b sz=%0d d=%0d dh=%0b dm=%0b s=%0d sh=%0b sm=%0b si=%0b imm=%h expected inv=0 sz=%0d d=%0d dh=%0b dm=%0b s=%0d sh=%0b sm=%0b si=%0b imm=%h",
                        e.req, out_invalid, out_size, out_dst, out_dst_hi, out_dst_mem,
                        out_src, out_src_hi, out_src_mem, out_src_imm, out_imm,
                        e.sz, e.d, e.dh, e.dm, e.s, e.sh, e.sm, e.si, e.imm);
            end
         end
      end
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin : main
      repeat (4) @(negedge clk);
      // reset state (R1, R2)
      n_chk++;
      if (in_ready !== 1'b1 || out_valid !== 1'b0) begin
         n_err++;
         $display("FAIL R1: reset in_ready=%0b out_valid=%0b expected 1 0", in_ready, out_valid);
      end
      rst_n = 1'b1;
      idle(3, 1'b1);

      // R4 accumulator, 8-bit
      push(mk("R4", 2'd0, 4'd0, 0, 0, 4'd0, 0, 0, 1, 64'h7F));
      put(8'h04); put(8'h7F); expect_emit("R2");
      // R4 accumulator, 32-bit, next instruction offered during record cycle
      push(mk("R4", 2'd2, 4'd0, 0, 0, 4'd0, 0, 0, 1, 64'h12345678));
      put(8'h05); put(8'h78); put(8'h56); put(8'h34); put(8'h12);
      // R3 0x66 gives 16 bits, 2-byte immediate
      push(mk("R3", 2'd1, 4'd0, 0, 0, 4'd0, 0, 0, 1, 64'hF234));
      put(8'h66); put(8'h05); put(8'h34); put(8'hF2);
      idle(2, 1'b1);
      // R10 64-bit accumulator, imm32 sign-extended
      push(mk("R10", 2'd3, 4'd0, 0, 0, 4'd0, 0, 0, 1, 64'hFFFFFFFF80000000));
      put(8'h48); put(8'h05); put(8'h00); put(8'h00); put(8'h00); put(8'h80);
      expect_emit("R2");
      // R5 0x83 at 32 bits, imm8 sign-extended and masked
      push(mk("R5", 2'd2, 4'd1, 0, 0, 4'd0, 0, 0, 1, 64'hFFFFFFFF));
      put(8'h83); put(8'hC1); put(8'hFF);
      // R10 0x83 at 64 bits
      push(mk("R10", 2'd3, 4'd1, 0, 0, 4'd0, 0, 0, 1, 64'hFFFFFFFFFFFFFF80));
      put(8'h48); put(8'h83); put(8'hC1); put(8'h80);
      // R9 high byte destination without REX
      push(mk("R9", 2'd0, 4'd4, 1, 0, 4'd0, 0, 0, 1, 64'h05));
      put(8'h80); put(8'hC4); put(8'h05);
      // R9 REX turns index 4 into a low byte register
      push(mk("R9", 2'd0, 4'd4, 0, 0, 4'd0, 0, 0, 1, 64'h05));
      put(8'h40); put(8'h80); put(8'hC4); put(8'h05);
      // R6 MR direction, high byte source
      push(mk("R6", 2'd0, 4'd0, 0, 0, 4'd4, 1, 0, 0, 64'd0));
      put(8'h00); put(8'hE0); expect_emit("R2");
      // R6 RM direction, high byte destination
      push(mk("R6", 2'd0, 4'd4, 1, 0, 4'd0, 0, 0, 0, 64'd0));
      put(8'h02); put(8'hE0);
      // R7 REX.W and REX.R
      push(mk("R7", 2'd3, 4'd0, 0, 0, 4'd9, 0, 0, 0, 64'd0));
      put(8'h4C); put(8'h01); put(8'hC8);
      // R7 REX.B on memory r/m source (R13)
      push(mk("R13", 2'd2, 4'd0, 0, 0, 4'd14, 0, 1, 0, 64'd0));
      put(8'h41); put(8'h03); put(8'h06);
      // R7 REX followed by a prefix is dropped; R3 0x66 applies
      push(mk("R7", 2'd1, 4'd0, 0, 0, 4'd1, 0, 0, 0, 64'd0));
      put(8'h48); put(8'h66); put(8'h01); put(8'hC8);
      // R5 group reg field 1: fault right after ModRM
      push(mkinv("R5"));
      put(8'h80); put(8'hC8); expect_emit("R5");
      // R11 LOCK with register destination
      push(mkinv("R11"));
      put(8'hF0); put(8'h01); put(8'hC8);
      // R11 LOCK with memory destination decodes (R13)
      push(mk("R11", 2'd2, 4'd0, 0, 1, 4'd1, 0, 0, 0, 64'd0));
      put(8'hF0); put(8'h01); put(8'h08);
      // R11 LOCK on accumulator form, immediate still consumed
      push(mkinv("R11"));
      put(8'hF0); put(8'h04); put(8'h11); expect_emit("R11");
      // R11 LOCK on RM form
      push(mkinv("R11"));
      put(8'hF0); put(8'h03); put(8'h08);
      // R12 unknown opcode
      push(mkinv("R12"));
      put(8'h0F); expect_emit("R12");
      // R13 memory destination, high byte source
      push(mk("R13", 2'd0, 4'd0, 0, 1, 4'd4, 1, 0, 0, 64'd0));
      put(8'h00); put(8'h20);
      // R5 0x81 at 16 bits on memory
      push(mk("R5", 2'd1, 4'd0, 0, 1, 4'd0, 0, 0, 1, 64'h1234));
      put(8'h66); put(8'h81); put(8'h00); put(8'h34); put(8'h12);

      // legacy mode
      idle(3, 1'b0);
      push(mkinv("R8"));
      put(8'h48); expect_emit("R8");
      push(mk("R8", 2'd2, 4'd0, 0, 0, 4'd0, 0, 0, 1, 64'h12345678));
      put(8'h05); put(8'h78); put(8'h56); put(8'h34); put(8'h12);
      push(mk("R8", 2'd1, 4'd0, 0, 0, 4'd0, 0, 0, 1, 64'h1234));
      put(8'h66); put(8'h05); put(8'h34); put(8'h12);
      push(mkinv("R8"));
      put(8'h40);
      push(mk("R8", 2'd2, 4'd0, 0, 0, 4'd1, 0, 0, 0, 64'd0));
      put(8'h01); put(8'hC8);

      idle(6, 1'b0);
      // R2 every expected record was produced
      n_chk++;
      if (sbq.size() != 0) begin
         n_err++;
         $display("FAIL R2: %0d records missing expected 0", sbq.size());
      end
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule